// File: doc/BRIEF.md
# Four-Bank External Parallel Bus Sequencer

This block converts single-beat read and write requests from an on-chip master into strobed cycles on an asynchronous external parallel bus. The bus serves four chip-select regions, and each region has its own settings. Per region the settings give the address-latch pulse length, the access length and the hold length. They also give three idle-gap lengths and an enable bit. Three mode bits select a byte-wide or halfword-wide data path, multiplexed or separate address and data lines, and an active-low or active-high chip select.

All phase lengths count ticks of the external bus clock. The block derives that clock from the system clock through a power-of-two divider. The requester raises `req_valid` and holds the request steady until `req_ready` pulses. `req_ready` pulses together with `rsp_done`, and for a read `rsp_rdata` is valid in that cycle. Between two accesses the block can insert an idle gap. The gap length comes from the region used last and from the direction of the previous and the next access. Every chip select is inactive during the gap.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the strobes (`bus_rd_n`, `bus_wr_n`) are high, `bus_ale`, `bus_doe`, `req_ready` and `rsp_done` are low, and every chip select sits at its inactive level.
- R2: A request to a region whose enable bit is 0 produces no strobe, no ALE and no chip select. It completes in the cycle after acceptance with `rsp_rdata` = 0, and it does not count as the previous access for gap selection.
- R3: In multiplexed mode (`cfg_split`=0), ALE is high for ale+1 ticks before the access, with the bus address driven on `bus_dout` and `bus_doe` high. In split mode there is no ALE phase and the address appears on `bus_addr`.
- R4: The access phase lasts acc+1 ticks, with `bus_rd_n` low for a read or `bus_wr_n` low for a write. The two strobes are never low together.
- R5: The hold phase follows the access for hold+1 ticks, with both strobes high, the chip select still active and, for a write, the write data still driven.
- R6: Read data is sampled from `bus_din` on the last cycle of the access phase and is returned on `rsp_rdata` with the completion pulse.
- R7: After a write, the next access is preceded by w2x ticks of the previous region's setting with all chip selects inactive. A value of 0 means no gap.
- R8: After a read, the next access is preceded by r2w ticks (next is a write) or r2r ticks (next is a read) of the previous region's settings. A value of 0 means no gap.
- R9: On a halfword region (`cfg_wide`=1) the bus address is the byte address shifted right by one and all 16 data bits are used. On a byte region the address is unshifted, written data has bits 15:8 at zero, and read data returns bits 15:8 as zero.
- R10: Only the addressed region's chip select goes active, only during its ALE, access and hold phases. The active level is 1 when its `cfg_cs_hi` bit is 1, otherwise 0.
- R11: `div_sel` codes 0..5 divide the system clock by 1, 2, 4, 8, 16, 32. Codes 6 and 7 act as 5. `bus_clk` is a 50% square wave at that period and is held high for code 0. Phases advance once per bus clock period.
- R12: `req_ready` and `rsp_done` are high together for exactly one cycle at the end of each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ale | input | 12 | Per-region ALE length, 3 bits each, region i at [3i+2:3i] |
| cfg_acc | input | 20 | Per-region access length, 5 bits each |
| cfg_hold | input | 12 | Per-region hold length, 3 bits each |
| cfg_w2x | input | 16 | Per-region gap after a write, 4 bits each |
| cfg_r2w | input | 16 | Per-region gap from read to write, 4 bits each |
| cfg_r2r | input | 16 | Per-region gap from read to read, 4 bits each |
| cfg_en | input | 4 | Per-region enable |
| cfg_wide | input | 4 | Per-region halfword data path |
| cfg_split | input | 4 | Per-region separate address lines |
| cfg_cs_hi | input | 4 | Per-region active-high chip select |
| div_sel | input | 3 | Bus clock divider code |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target region |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request completed and taken |
| rsp_done | output | 1 | Completion pulse |
| rsp_rdata | output | 16 | Read data |
| bus_clk | output | 1 | Divided external bus clock |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_cs | output | 4 | Chip selects at the configured polarity |
| bus_addr | output | 16 | Address lines in split mode |
| bus_doe | output | 1 | Data output enable |
| bus_dout | output | 16 | Outgoing address/data lines |
| bus_din | input | 16 | Incoming data lines |

## Verification
The properties assume that the per-region settings and the divider code do not change while a request is pending. They also assume that the request fields stay constant from the rise of `req_valid` until `req_ready`. The stimulus loads every setting before reset is released. It changes the divider only while the sequencer is idle, and it drives all request fields together with `req_valid`, keeping them constant until the completion pulse is seen. The only input that moves during an access is the incoming data: one directed read changes it every access cycle to show which cycle is sampled.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int ALE_W   = 3;
  localparam int ACC_W   = 5;
  localparam int HOLD_W  = 3;
  localparam int GAP_W   = 4;
  localparam int DIV_W   = 3;
  localparam int DIV_MAX = 5;
  localparam int CNT_W   = ACC_W;

  typedef struct packed {
    logic [ALE_W-1:0]  ale;
    logic [ACC_W-1:0]  acc;
    logic [HOLD_W-1:0] hold;
    logic [GAP_W-1:0]  w2x;
    logic [GAP_W-1:0]  r2w;
    logic [GAP_W-1:0]  r2r;
    logic              en;
    logic              wide;
    logic              split;
    logic              cs_hi;
  } bank_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GAP, ST_ALE, ST_ACC, ST_HOLD, ST_DONE
  } seq_st_t;
endpackage

// File: rtl/xbus_clkgen.sv
module xbus_clkgen #(
  parameter int DIV_W   = 3,
  parameter int DIV_MAX = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick,
  output logic             bus_clk
);
  localparam int CW = DIV_MAX;

  logic [CW-1:0]    cnt;
  logic [DIV_W-1:0] sel_c;
  logic [CW-1:0]    mask;
  logic [CW:0]      ext;

  assign sel_c = (div_sel > DIV_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : div_sel;
  assign mask  = CW'((32'd1 << sel_c) - 32'd1);
  assign tick  = ((cnt & mask) == mask);
  assign ext   = {cnt, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      bus_clk <= 1'b1;
    end else begin
      cnt     <= cnt + 1'b1;
      bus_clk <= ext[sel_c];
    end
  end
endmodule

// File: rtl/xbus_gap_sel.sv
module xbus_gap_sel #(
  parameter int GAP_W = 4
) (
  input  logic             hist_valid,
  input  logic             hist_write,
  input  logic             next_write,
  input  logic [GAP_W-1:0] w2x,
  input  logic [GAP_W-1:0] r2w,
  input  logic [GAP_W-1:0] r2r,
  output logic [GAP_W-1:0] gap_len
);
  always_comb begin
    if (!hist_valid)     gap_len = '0;
    else if (hist_write) gap_len = w2x;
    else if (next_write) gap_len = r2w;
    else                 gap_len = r2r;
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  bank_cfg_t         req_cfg,
  input  bank_cfg_t         act_cfg,
  input  logic [GAP_W-1:0]  gap_len,
  input  logic [DATA_W-1:0] bus_din,
  output logic              ph_ale,
  output logic              ph_acc,
  output logic              ph_hold,
  output logic              done,
  output logic              act_write,
  output logic [BANK_W-1:0] act_bank,
  output logic [ADDR_W-1:0] act_addr,
  output logic [DATA_W-1:0] act_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              hist_valid,
  output logic              hist_write,
  output logic [BANK_W-1:0] hist_bank
);
  localparam int BYTE_W = 8;

  seq_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last    = tick && (cnt == '0);
  assign ph_ale  = (st == ST_ALE);
  assign ph_acc  = (st == ST_ACC);
  assign ph_hold = (st == ST_HOLD);
  assign done    = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      act_write  <= 1'b0;
      act_bank   <= '0;
      act_addr   <= '0;
      act_wdata  <= '0;
      rdata      <= '0;
      hist_valid <= 1'b0;
      hist_write <= 1'b0;
      hist_bank  <= '0;
    end else begin
      if (tick && !last) cnt <= cnt - 1'b1;
      case (st)
        ST_IDLE: if (req_valid && tick) begin
          act_write <= req_write;
          act_bank  <= req_bank;
          act_addr  <= req_cfg.wide ? (req_addr >> 1) : req_addr;
          act_wdata <= req_cfg.wide ? req_wdata
                                    : {{(DATA_W-BYTE_W){1'b0}}, req_wdata[BYTE_W-1:0]};
          if (!req_cfg.en) begin
            st    <= ST_DONE;
            rdata <= '0;
          end else if (gap_len != '0) begin
            st  <= ST_GAP;
            cnt <= CNT_W'(gap_len) - 1'b1;
          end else if (req_cfg.split) begin
            st  <= ST_ACC;
            cnt <= req_cfg.acc;
          end else begin
            st  <= ST_ALE;
            cnt <= CNT_W'(req_cfg.ale);
          end
        end
        ST_GAP: if (last) begin
          if (act_cfg.split) begin
            st  <= ST_ACC;
            cnt <= act_cfg.acc;
          end else begin
            st  <= ST_ALE;
            cnt <= CNT_W'(act_cfg.ale);
          end
        end
        ST_ALE: if (last) begin
          st  <= ST_ACC;
          cnt <= act_cfg.acc;
        end
        ST_ACC: if (last) begin
          st  <= ST_HOLD;
          cnt <= CNT_W'(act_cfg.hold);
          if (!act_write)
            rdata <= act_cfg.wide ? bus_din
                                  : {{(DATA_W-BYTE_W){1'b0}}, bus_din[BYTE_W-1:0]};
        end
        ST_HOLD: if (last) begin
          st         <= ST_DONE;
          hist_valid <= 1'b1;
          hist_write <= act_write;
          hist_bank  <= act_bank;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NBANK*ALE_W-1:0]    cfg_ale,
  input  logic [NBANK*ACC_W-1:0]    cfg_acc,
  input  logic [NBANK*HOLD_W-1:0]   cfg_hold,
  input  logic [NBANK*GAP_W-1:0]    cfg_w2x,
  input  logic [NBANK*GAP_W-1:0]    cfg_r2w,
  input  logic [NBANK*GAP_W-1:0]    cfg_r2r,
  input  logic [NBANK-1:0]          cfg_en,
  input  logic [NBANK-1:0]          cfg_wide,
  input  logic [NBANK-1:0]          cfg_split,
  input  logic [NBANK-1:0]          cfg_cs_hi,
  input  logic [DIV_W-1:0]          div_sel,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [BANK_W-1:0]         req_bank,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      req_ready,
  output logic                      rsp_done,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      bus_clk,
  output logic                      bus_ale,
  output logic                      bus_rd_n,
  output logic                      bus_wr_n,
  output logic [NBANK-1:0]          bus_cs,
  output logic [ADDR_W-1:0]         bus_addr,
  output logic                      bus_doe,
  output logic [DATA_W-1:0]         bus_dout,
  input  logic [DATA_W-1:0]         bus_din
);
  bank_cfg_t cfg [NBANK];
  bank_cfg_t req_cfg, act_cfg, hist_cfg;

  logic              tick;
  logic              ph_ale, ph_acc, ph_hold, done;
  logic              act_write, hist_valid, hist_write;
  logic [BANK_W-1:0] act_bank, hist_bank;
  logic [ADDR_W-1:0] act_addr;
  logic [DATA_W-1:0] act_wdata;
  logic [GAP_W-1:0]  gap_len;
  logic              cs_on, wr_drive;

  for (genvar g = 0; g < NBANK; g++) begin : g_cfg
    assign cfg[g].ale   = cfg_ale[g*ALE_W +: ALE_W];
    assign cfg[g].acc   = cfg_acc[g*ACC_W +: ACC_W];
    assign cfg[g].hold  = cfg_hold[g*HOLD_W +: HOLD_W];
    assign cfg[g].w2x   = cfg_w2x[g*GAP_W +: GAP_W];
    assign cfg[g].r2w   = cfg_r2w[g*GAP_W +: GAP_W];
    assign cfg[g].r2r   = cfg_r2r[g*GAP_W +: GAP_W];
    assign cfg[g].en    = cfg_en[g];
    assign cfg[g].wide  = cfg_wide[g];
    assign cfg[g].split = cfg_split[g];
    assign cfg[g].cs_hi = cfg_cs_hi[g];
  end

  assign req_cfg  = cfg[req_bank];
  assign act_cfg  = cfg[act_bank];
  assign hist_cfg = cfg[hist_bank];

  xbus_clkgen #(.DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) clkgen_i (
    .clk(clk), .rst(rst), .div_sel(div_sel), .tick(tick), .bus_clk(bus_clk)
  );

  xbus_gap_sel #(.GAP_W(GAP_W)) gap_i (
    .hist_valid(hist_valid), .hist_write(hist_write), .next_write(req_write),
    .w2x(hist_cfg.w2x), .r2w(hist_cfg.r2w), .r2r(hist_cfg.r2r), .gap_len(gap_len)
  );

  xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) seq_i (
    .clk(clk), .rst(rst), .tick(tick),
    .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_cfg(req_cfg), .act_cfg(act_cfg), .gap_len(gap_len), .bus_din(bus_din),
    .ph_ale(ph_ale), .ph_acc(ph_acc), .ph_hold(ph_hold), .done(done),
    .act_write(act_write), .act_bank(act_bank), .act_addr(act_addr),
    .act_wdata(act_wdata), .rdata(rsp_rdata),
    .hist_valid(hist_valid), .hist_write(hist_write), .hist_bank(hist_bank)
  );

  assign cs_on    = ph_ale | ph_acc | ph_hold;
  assign wr_drive = act_write & (ph_acc | ph_hold);

  assign req_ready = done;
  assign rsp_done  = done;
  assign bus_ale   = ph_ale;
  assign bus_rd_n  = ~(ph_acc & ~act_write);
  assign bus_wr_n  = ~(ph_acc & act_write);
  assign bus_doe   = ph_ale | wr_drive;
  assign bus_addr  = (act_cfg.split && cs_on) ? act_addr : '0;
  assign bus_dout  = ph_ale   ? DATA_W'(act_addr) :
                     wr_drive ? act_wdata : '0;

  for (genvar g = 0; g < NBANK; g++) begin : g_cs
    assign bus_cs[g] = (cs_on && (act_bank == BANK_W'(g))) ? cfg_cs_hi[g] : ~cfg_cs_hi[g];
  end
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_ale,
  input logic             bus_rd_n,
  input logic             bus_wr_n,
  input logic             bus_doe,
  input logic [NBANK-1:0] bus_cs,
  input logic [NBANK-1:0] cfg_cs_hi,
  input logic             rsp_done
);
  logic [NBANK-1:0] cs_act;
  assign cs_act = ~(bus_cs ^ cfg_cs_hi);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n));

  p_ale_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> (bus_rd_n && bus_wr_n && bus_doe));

  p_cs_single_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_act));

  p_strobe_has_cs_r10: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n || !bus_wr_n) |-> ($countones(cs_act) == 1));

  p_rd_released_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_doe);

  p_wr_kept_r5: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |=> bus_doe);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  p_done_bus_idle_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (bus_rd_n && bus_wr_n && !bus_ale && (cs_act == '0)));
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.NBANK(NBANK)) chk_i (
  .clk(clk), .rst(rst), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n),
  .bus_wr_n(bus_wr_n), .bus_doe(bus_doe), .bus_cs(bus_cs),
  .cfg_cs_hi(cfg_cs_hi), .rsp_done(rsp_done)
);

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;

  typedef struct packed {
    logic        wr;
    logic [1:0]  bank;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [15:0] din;
    logic [15:0] rdata;
    logic [3:0]  gap;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 2'd0, 16'h1234, 16'hABCD, 16'h0000, 16'h0000, 4'd0},
    '{1'b0, 2'd0, 16'h0055, 16'h0000, 16'h7E5A, 16'h005A, 4'd2},
    '{1'b0, 2'd0, 16'h0101, 16'h0000, 16'h00C3, 16'h00C3, 4'd1},
    '{1'b1, 2'd1, 16'h0400, 16'h1357, 16'h0000, 16'h0000, 4'd3},
    '{1'b0, 2'd1, 16'h0402, 16'h0000, 16'hBEEF, 16'hBEEF, 4'd0},
    '{1'b0, 2'd2, 16'h0A06, 16'h0000, 16'h2468, 16'h2468, 4'd0},
    '{1'b1, 2'd2, 16'h0010, 16'h55AA, 16'h0000, 16'h0000, 4'd2},
    '{1'b1, 2'd0, 16'h00FF, 16'h1122, 16'h0000, 16'h0000, 4'd1},
    '{1'b0, 2'd3, 16'h0020, 16'h0000, 16'hFFFF, 16'h0000, 4'd0},
    '{1'b0, 2'd2, 16'h0002, 16'h0000, 16'h0F0F, 16'h0F0F, 4'd2}
  };

  int c_ale  [NB] = '{1, 0, 2, 1};
  int c_acc  [NB] = '{2, 0, 4, 1};
  int c_hold [NB] = '{1, 0, 2, 1};
  int c_w2x  [NB] = '{2, 0, 1, 1};
  int c_r2w  [NB] = '{3, 0, 2, 1};
  int c_r2r  [NB] = '{1, 0, 3, 1};
  int c_en   [NB] = '{1, 1, 1, 0};
  int c_wide [NB] = '{0, 1, 1, 0};
  int c_split[NB] = '{0, 1, 0, 1};
  int c_cshi [NB] = '{0, 1, 0, 0};

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] cfg_ale, cfg_hold;
  logic [19:0] cfg_acc;
  logic [15:0] cfg_w2x, cfg_r2w, cfg_r2r;
  logic [3:0]  cfg_en, cfg_wide, cfg_split, cfg_cs_hi;
  logic [2:0]  div_sel;
  logic        req_valid, req_write;
  logic [1:0]  req_bank;
  logic [15:0] req_addr, req_wdata;
  logic        req_ready, rsp_done;
  logic [15:0] rsp_rdata;
  logic        bus_clk, bus_ale, bus_rd_n, bus_wr_n, bus_doe;
  logic [3:0]  bus_cs;
  logic [15:0] bus_addr, bus_dout, bus_din;

  int total = 0;
  int bad   = 0;
  int obs_cycles, obs_ale, obs_strobe, obs_cs, obs_other, obs_hold_drv;
  int obs_addr, obs_wd, obs_rdata, obs_done, obs_after;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_ctrl dut_i (
    .clk(clk), .rst(rst),
    .cfg_ale(cfg_ale), .cfg_acc(cfg_acc), .cfg_hold(cfg_hold),
    .cfg_w2x(cfg_w2x), .cfg_r2w(cfg_r2w), .cfg_r2r(cfg_r2r),
    .cfg_en(cfg_en), .cfg_wide(cfg_wide), .cfg_split(cfg_split), .cfg_cs_hi(cfg_cs_hi),
    .div_sel(div_sel),
    .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_clk(bus_clk), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_cs(bus_cs), .bus_addr(bus_addr), .bus_doe(bus_doe), .bus_dout(bus_dout),
    .bus_din(bus_din)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic wr, input logic [1:0] bank, input logic [15:0] addr,
                         input logic [15:0] wdata, input logic [15:0] din, input bit ramp);
    bit seen_ale = 0;
    bit seen_st  = 0;
    bit fin      = 0;
    req_write = wr; req_bank = bank; req_addr = addr; req_wdata = wdata;
    bus_din = din; req_valid = 1'b1;
    obs_cycles = 0; obs_ale = 0; obs_strobe = 0; obs_cs = 0; obs_other = 0;
    obs_hold_drv = 0; obs_addr = -1; obs_wd = -1;
    for (int k = 0; k < 400 && !fin; k++) begin
      @(posedge clk); @(negedge clk);
      if (req_ready) begin
        obs_rdata = int'(rsp_rdata);
        obs_done  = int'(rsp_done);
        fin = 1;
      end else begin
        obs_cycles++;
        if (bus_ale) begin
          if (!seen_ale) obs_addr = int'(bus_dout);
          seen_ale = 1;
          obs_ale++;
        end
        if (wr ? !bus_wr_n : !bus_rd_n) begin
          if (!seen_st) begin
            if (c_split[bank] != 0) obs_addr = int'(bus_addr);
            obs_wd = int'(bus_dout);
          end
          seen_st = 1;
          obs_strobe++;
          if (ramp) bus_din = 16'h0FFF + 16'(obs_strobe);
        end else begin
          if (ramp && seen_st) bus_din = 16'hDEAD;
          if (seen_st && wr && bus_doe && bus_dout == obs_wd[15:0]) obs_hold_drv++;
        end
        for (int b = 0; b < NB; b++)
          if (int'(bus_cs[b]) == c_cshi[b]) begin
            if (b == int'(bank)) obs_cs++; else obs_other++;
          end
      end
    end
    if (!fin) chk("R12 handshake timeout", 0, 1);
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    obs_after = int'({req_ready, rsp_done});
  endtask

  task automatic measure_clk(input logic [2:0] sel, input int exp_rise, input int exp_high);
    int rises = 0;
    int highs = 0;
    logic prev;
    div_sel = sel;
    repeat (40) @(negedge clk);
    prev = bus_clk;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (bus_clk && !prev) rises++;
      if (bus_clk) highs++;
      prev = bus_clk;
    end
    chk($sformatf("R11 div code %0d rising edges", sel), rises, exp_rise);
    chk($sformatf("R11 div code %0d high cycles", sel), highs, exp_high);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      cfg_ale[i*3 +: 3]   = 3'(c_ale[i]);
      cfg_acc[i*5 +: 5]   = 5'(c_acc[i]);
      cfg_hold[i*3 +: 3]  = 3'(c_hold[i]);
      cfg_w2x[i*4 +: 4]   = 4'(c_w2x[i]);
      cfg_r2w[i*4 +: 4]   = 4'(c_r2w[i]);
      cfg_r2r[i*4 +: 4]   = 4'(c_r2r[i]);
      cfg_en[i]    = c_en[i][0];
      cfg_wide[i]  = c_wide[i][0];
      cfg_split[i] = c_split[i][0];
      cfg_cs_hi[i] = c_cshi[i][0];
    end
    rst = 1'b1; div_sel = 3'd0; req_valid = 1'b0; req_write = 1'b0;
    req_bank = '0; req_addr = '0; req_wdata = '0; bus_din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state, inactive chip-select levels are 1,1,0,1 for regions 3..0
    chk("R1 cs in reset", int'(bus_cs), 4'b1101);
    chk("R1 strobes/ale/doe in reset", int'({bus_rd_n, bus_wr_n, bus_ale, bus_doe}), 4'b1100);
    chk("R1 ready/done in reset", int'({req_ready, rsp_done}), 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 cs after reset", int'(bus_cs), 4'b1101);
    chk("R1 strobes after reset", int'({bus_rd_n, bus_wr_n, bus_ale, bus_doe}), 4'b1100);

    for (int v = 0; v < NVEC; v++) begin
      automatic int b  = int'(VEC[v].bank);
      automatic int en = c_en[b];
      automatic int ph = (c_split[b] != 0 ? 0 : c_ale[b] + 1) + c_acc[b] + 1 + c_hold[b] + 1;
      automatic int ea = (c_wide[b] != 0) ? int'(VEC[v].addr >> 1) : int'(VEC[v].addr);
      automatic int ew = (c_wide[b] != 0) ? int'(VEC[v].wdata) : int'(VEC[v].wdata & 16'h00FF);
      run_txn(VEC[v].wr, VEC[v].bank, VEC[v].addr, VEC[v].wdata, VEC[v].din, 1'b0);
      if (en == 0) begin
        chk($sformatf("R2 v%0d cycles", v), obs_cycles, 0);
        chk($sformatf("R2 v%0d strobes", v), obs_strobe + obs_ale, 0);
        chk($sformatf("R2 v%0d cs", v), obs_cs + obs_other, 0);
        chk($sformatf("R2 v%0d rdata", v), obs_rdata, 0);
      end else begin
        chk($sformatf("R7 R8 v%0d total cycles incl gap", v), obs_cycles, int'(VEC[v].gap) + ph);
        chk($sformatf("R3 v%0d ale cycles", v), obs_ale, c_split[b] != 0 ? 0 : c_ale[b] + 1);
        chk($sformatf("R4 v%0d strobe cycles", v), obs_strobe, c_acc[b] + 1);
        chk($sformatf("R10 v%0d cs active cycles", v), obs_cs, ph);
        chk($sformatf("R10 v%0d other cs", v), obs_other, 0);
        chk($sformatf("R9 v%0d bus address", v), obs_addr, ea);
        if (VEC[v].wr) begin
          chk($sformatf("R9 v%0d write data", v), obs_wd, ew);
          chk($sformatf("R5 v%0d data held", v), obs_hold_drv, c_hold[b] + 1);
        end else begin
          chk($sformatf("R6 v%0d read data", v), obs_rdata, int'(VEC[v].rdata));
        end
      end
      chk($sformatf("R12 v%0d done with ready", v), obs_done, 1);
      chk($sformatf("R12 v%0d one-cycle pulse", v), obs_after, 0);
    end

    // R6: incoming data changes every access cycle; the last one must be kept
    run_txn(1'b0, 2'd2, 16'h0004, 16'h0000, 16'h0000, 1'b1);
    chk("R6 sampled on last access cycle", obs_rdata, 16'h1004);

    measure_clk(3'd2, 16, 32);
    measure_clk(3'd5, 2, 32);
    measure_clk(3'd7, 2, 32);
    measure_clk(3'd0, 0, 64);

    // R11: at divide-by-2 a single-tick access holds the strobe two system cycles
    div_sel = 3'd1;
    @(negedge clk);
    run_txn(1'b0, 2'd1, 16'h0010, 16'h0000, 16'h4321, 1'b0);
    chk("R11 strobe stretched by divider", obs_strobe, 2);
    chk("R11 read data at divide-by-2", obs_rdata, 16'h4321);
    div_sel = 3'd0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule